// File: doc/BRIEF.md
# Serial Leading-One Position Search

This unit reports where the highest set bit sits in a data word. It does not use a one-cycle priority encoder. It walks the word one bit per clock. A load strobe captures the word into a shift register and presets a down counter to the top bit position. On every enabled cycle the unit looks at the bit currently at the top of the register. If that bit is 0, the word moves one place toward the top and the counter steps down. If that bit is 1, the search stops and the counter holds the answer.

The search costs one cycle for a word whose top bit is set and up to WIDTH cycles for a word whose only set bit is bit 0. An all-zero word also takes WIDTH cycles; it ends with a flag that marks the word as empty. A separate enable input pauses the walk without losing its place. The result stays on the outputs until the next load.

Top module: `lead_one_seq`

## Requirements
- R1: After reset, `found_o` and `empty_o` are 0 and `pos_o` is 0.
- R2: A cycle with `load_i` high captures `word_i` and starts a new search. From the next cycle `found_o` and `empty_o` are 0 until that search ends. Load takes priority over every other input.
- R3: The search advances at most one bit per clock, and only on cycles with `step_en_i` high. A cycle with `step_en_i` low leaves the search where it was.
- R4: For a nonzero word, `pos_o` equals the index of its highest set bit (0 = least significant) once `found_o` is high.
- R5: With `step_en_i` held high, `found_o` first reads 1 exactly WIDTH − `pos_o` clock edges after the load edge. Each disabled cycle in between adds one edge.
- R6: For an all-zero word, the search ends after WIDTH enabled cycles with `found_o` = 1, `empty_o` = 1 and `pos_o` = 0.
- R7: Once the search ends, `found_o`, `empty_o` and `pos_o` hold their values, whatever `step_en_i` does, until the next load.
- R8: A load issued while a search is still running drops that search. The result and its latency then refer only to the newly loaded word.
- R9: A search over a nonzero word ends with `empty_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `word_i` and restart the search |
| word_i | input | WIDTH | Word to be searched |
| step_en_i | input | 1 | Allows the search to advance this cycle |
| pos_o | output | $clog2(WIDTH) | Index of the highest set bit |
| found_o | output | 1 | Search finished; outputs are valid |
| empty_o | output | 1 | The finished search saw an all-zero word |

## Verification
Every one of the 256 possible words is searched, and the bench checks both the reported position and the number of edges the search took.

The corner cases it targets, and how a faulty design would show up:
- Bit 0 as the only set bit, and the zero word. Both need the full WIDTH cycles. A counter that wrapped or stopped one step early would give a wrong position or a short latency.
- Searches with the enable toggling. A design that shifted on disabled cycles would finish too soon.
- A reload in the middle of a search. A design that kept the stale word or counter would report the old answer.
- The held result. A design that kept shifting after the search ended would change the position while `found_o` stays high.

// File: rtl/lead_one_pkg.sv
package lead_one_pkg;

    typedef enum logic [1:0] {
        LO_IDLE   = 2'd0,
        LO_SEARCH = 2'd1,
        LO_FOUND  = 2'd2
    } lo_state_e;

    typedef struct packed {
        lo_state_e state;
        logic      empty;
    } lo_ctrl_s;

endpackage

// File: rtl/lead_one_shreg.sv
module lead_one_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] word_i,
    output logic             top_bit_o
);
    logic [WIDTH-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) begin
            word_d = word_i;
        end else if (step_i) begin
            word_d = {word_q[WIDTH-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign top_bit_o = word_q[WIDTH-1];

    // R3: a step never happens in the same cycle as a load
    a_r3_step_not_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !load_i);
endmodule

// File: rtl/lead_one_count.sv
module lead_one_count #(
    parameter int WIDTH = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    output logic [IW-1:0] cnt_o,
    output logic          cnt_zero_o
);
    localparam logic [IW-1:0] TOP_POS = IW'(WIDTH - 1);

    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = TOP_POS;
        end else if (step_i) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o      = cnt_q;
    assign cnt_zero_o = (cnt_q == '0);

    // R6: the controller never asks for a step once the counter sits at zero
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> cnt_q != '0);

    // R2: a load presets the counter to the top bit position
    a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == TOP_POS);
endmodule

// File: rtl/lead_one_ctrl.sv
module lead_one_ctrl
    import lead_one_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_en_i,
    input  logic top_bit_i,
    input  logic cnt_zero_i,
    output logic step_o,
    output logic found_o,
    output logic empty_o
);
    lo_ctrl_s ctl_d, ctl_q;
    logic     step_d;

    always_comb begin
        ctl_d  = ctl_q;
        step_d = 1'b0;
        if (load_i) begin
            ctl_d.state = LO_SEARCH;
            ctl_d.empty = 1'b0;
        end else begin
            case (ctl_q.state)
                LO_SEARCH: begin
                    if (step_en_i) begin
                        if (top_bit_i || cnt_zero_i) begin
                            ctl_d.state = LO_FOUND;
                            ctl_d.empty = !top_bit_i;
                        end else begin
                            step_d = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: LO_IDLE, empty: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign step_o  = step_d;
    assign found_o = (ctl_q.state == LO_FOUND);
    assign empty_o = ctl_q.empty;

    // R2: a load clears both flags on the next cycle
    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !found_o && !empty_o);

    // R3: a disabled cycle keeps a running search running
    a_r3_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == LO_SEARCH) && !step_en_i && !load_i |=> ctl_q.state == LO_SEARCH);

    // R7: a finished search stays finished until a load
    a_r7_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        found_o && !load_i |=> found_o && $stable(empty_o));
endmodule

// File: rtl/lead_one_seq.sv
module lead_one_seq #(
    parameter int WIDTH = 8,
    localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             step_en_i,
    output logic [IW-1:0]    pos_o,
    output logic             found_o,
    output logic             empty_o
);
    logic step;
    logic top_bit;
    logic cnt_zero;

    lead_one_shreg #(.WIDTH(WIDTH)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .step_i    (step),
        .word_i    (word_i),
        .top_bit_o (top_bit)
    );

    lead_one_count #(.WIDTH(WIDTH), .IW(IW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .step_i     (step),
        .cnt_o      (pos_o),
        .cnt_zero_o (cnt_zero)
    );

    lead_one_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .step_en_i  (step_en_i),
        .top_bit_i  (top_bit),
        .cnt_zero_i (cnt_zero),
        .step_o     (step),
        .found_o    (found_o),
        .empty_o    (empty_o)
    );

    // R7: the reported position does not move while the result is held
    a_r7_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        found_o && !load_i |=> $stable(pos_o));

    // R6: an empty result always reports position 0
    a_r6_empty_pos: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> found_o && pos_o == '0);

    // R4 / R9: a nonzero result has a one at the inspected top bit
    a_r4_top_is_one: assert property (@(posedge clk) disable iff (!rst_n)
        found_o && !empty_o |-> top_bit);
endmodule

// File: tb/tb_lead_one_seq.sv
module tb_lead_one_seq;
    localparam int WIDTH = 8;
    localparam int IW    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_i = 1'b0;
    logic [WIDTH-1:0] word_i = '0;
    logic             step_en_i = 1'b0;
    logic [IW-1:0]    pos_o;
    logic             found_o;
    logic             empty_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int pos;
        bit empty;
        int lat;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    lead_one_seq #(.WIDTH(WIDTH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .word_i    (word_i),
        .step_en_i (step_en_i),
        .pos_o     (pos_o),
        .found_o   (found_o),
        .empty_o   (empty_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int msb_pos(input logic [WIDTH-1:0] w);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (w[i]) return i;
        end
        return -1;
    endfunction

    // monitor: counts edges since the last load and scores each finished search
    initial begin
        int  cyc;
        bit  armed;
        bit  ld;
        exp_t e;
        cyc   = 0;
        armed = 1'b0;
        forever begin
            @(posedge clk);
            ld = load_i;
            #1;
            if (!rst_n) begin
                armed = 1'b0;
            end else begin
                if (ld) begin
                    cyc   = 0;
                    armed = 1'b1;
                end else begin
                    cyc++;
                end
                if (armed && found_o) begin
                    armed = 1'b0;
                    if (sb.size() == 0) begin
                        check(1'b0, "R4 unexpected result", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        check(int'(pos_o) == e.pos, e.empty ? "R6 pos" : "R4 pos", int'(pos_o), e.pos);
                        check(empty_o == e.empty, e.empty ? "R6 empty" : "R9 empty", int'(empty_o), int'(e.empty));
                        check(cyc == e.lat, "R5 latency", cyc, e.lat);
                    end
                end
            end
        end
    end

    // driver: one search with optional stalls, then a hold check
    task automatic run_word(input logic [WIDTH-1:0] w, input bit stall, input bit push);
        int   k;
        int   p;
        int   hp;
        bit   he;
        exp_t e;
        p       = msb_pos(w);
        e.pos   = (p < 0) ? 0 : p;
        e.empty = (p < 0);
        e.lat   = (p < 0) ? WIDTH : (WIDTH - p);
        if (stall) e.lat = 2 * e.lat;
        @(negedge clk);
        load_i    = 1'b1;
        word_i    = w;
        step_en_i = 1'b1;
        if (push) sb.push_back(e);
        @(negedge clk);
        load_i = 1'b0;
        check(!found_o && !empty_o, "R2 flags cleared by load", int'(found_o), 0);
        k = 1;
        step_en_i = stall ? 1'b0 : 1'b1;
        forever begin
            @(negedge clk);
            if (found_o) break;
            k++;
            step_en_i = stall ? ~k[0] : 1'b1;
        end
        hp = int'(pos_o);
        he = empty_o;
        for (int j = 0; j < 3; j++) begin
            step_en_i = j[0];
            @(negedge clk);
            check(found_o && int'(pos_o) == hp && empty_o == he, "R7 result held", int'(pos_o), hp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!found_o && !empty_o && pos_o == '0, "R1 reset state", int'(pos_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!found_o && !empty_o && pos_o == '0, "R1 idle after reset", int'(found_o), 0);

        // R4 R5 R6 R9: every word, enable held high
        for (int v = 0; v < 256; v++) begin
            run_word(WIDTH'(v), 1'b0, 1'b1);
        end

        // R3: pauses on alternate cycles double the latency, same answer
        run_word(8'h01, 1'b1, 1'b1);
        run_word(8'h00, 1'b1, 1'b1);
        run_word(8'h80, 1'b1, 1'b1);
        run_word(8'h2C, 1'b1, 1'b1);

        // R3: a long pause leaves the search unfinished
        @(negedge clk);
        load_i = 1'b1; word_i = 8'h01; step_en_i = 1'b0;
        @(negedge clk);
        load_i = 1'b0;
        repeat (12) @(negedge clk);
        check(!found_o, "R3 paused search idle", int'(found_o), 0);

        // R8: reload in the middle of a search
        load_i = 1'b1; word_i = 8'h01; step_en_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        repeat (2) @(negedge clk);
        check(!found_o, "R8 first search still running", int'(found_o), 0);
        run_word(8'h10, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R4 all results seen", sb.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule